// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit sits next to a small 8-bit processor core and handles hardware and software interrupts for it. It keeps an interrupt mask and an interrupt status byte. External request pulses and the core's software-interrupt instruction set status bits. Whenever the core reports that it is between instructions, the unit checks for pending interrupts. A pending interrupt is a status bit that is also enabled in the mask.

When an interrupt is taken, the unit raises `busy` to stall fetch. It then drives the core's memory port to push the machine state onto the stack, which grows downward. Next it reads the handler address from a vector table at the top of memory and loads it into the program counter. The matching return instruction runs the reverse sequence. That sequence pops the saved state, restores the stack pointer and re-enables the mask that was in force before entry. The core stays passive during both sequences: it only applies the load strobes and serves memory reads with one cycle of latency.

Top module: `intDispatch`

## Requirements
- R1: After reset, mask and status both read 0. An entry starts only in a cycle where `instrBoundary` is high, the unit is idle, `halted` is low and the AND of mask and status is non-zero. With mask 0, a boundary starts nothing.
- R2: When several interrupts are pending, the lowest-numbered pending bit is serviced first.
- R3: On entry, the mask is saved and then cleared to 0. Only the serviced status bit is cleared; the other status bits keep their values.
- R4: Entry performs nine memory writes at descending addresses SP-1 down to SP-9. The values written are, in order: the PC, the flags, then R0 up to R6. The stack pointer is then loaded with SP-9.
- R5: After the pushes, the unit reads address 0xF8 plus the interrupt number and loads that byte into the PC.
- R6: When `iretStrobe` is high at a boundary, the unit pops from ascending addresses starting at SP. The pops go to R6 down to R0, then the flags, then the PC. It then loads SP+9 and restores the mask saved at entry.
- R7: A one-cycle pulse on bit i of `irqReq` sets status bit i. `intStrobe` with number `intNum` sets status bit `intNum`. Neither changes the mask.
- R8: While `halted` is high, pending interrupts stay pending and no entry starts.
- R9: `busy` is high from the accepting cycle to the last cycle of a sequence. That is 12 cycles for an entry and 19 cycles for a return.
- R10: At most one memory operation is issued per cycle. Read data is taken one cycle after `memRdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | External request pulses, one per interrupt |
| intStrobe | input | 1 | Software interrupt request |
| intNum | input | 3 | Interrupt number for `intStrobe` |
| imWrEn | input | 1 | Mask write enable |
| imWrData | input | 8 | Mask write value |
| imOut | output | 8 | Current mask |
| isOut | output | 8 | Current status |
| instrBoundary | input | 1 | Core is between instructions |
| halted | input | 1 | Core is halted |
| iretStrobe | input | 1 | Instruction at this boundary is a return from interrupt |
| busy | output | 1 | Stall fetch |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 8 | Memory address |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Read data, valid one cycle after `memRdEn` |
| spIn | input | 8 | Current stack pointer |
| spLoad | output | 1 | Load stack pointer |
| spOut | output | 8 | New stack pointer |
| pcIn | input | 8 | Current program counter |
| pcLoad | output | 1 | Load program counter |
| pcOut | output | 8 | New program counter |
| flagsIn | input | 8 | Current flags |
| flagsLoad | output | 1 | Load flags |
| flagsOut | output | 8 | Restored flags |
| regRdIdx | output | 3 | Register file read index |
| regRdData | input | 8 | Register file read data |
| regWrEn | output | 1 | Register file write strobe |
| regWrIdx | output | 3 | Register file write index |
| regWrData | output | 8 | Register file write data |

## Verification
The bench raises all eight requests at once. It then services them one after another, once per interrupt number. Because each number sees different register, flags and PC contents, a swapped push slot or a wrong vector offset shows up. This run also shows the lowest-first order and that status bits clear one at a time. Before each return, every register is overwritten, so the restored values can only come from the stack. A software interrupt is then held back, first by a zero mask and then by the halted input, before it is finally taken. This separates the gating conditions from the request path.

// File: rtl/intDispatchPkg.sv
package intDispatchPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC_RD,
    ST_VEC_LD,
    ST_POP_RD,
    ST_POP_WB
  } seqState_t;

  typedef struct packed {
    logic accept;   // take the chosen interrupt
    logic latchSp;  // start a return, capture SP
    logic pushEn;   // write one stack slot
    logic vecRd;    // read the vector byte
    logic vecLoad;  // load PC and SP after entry
    logic popRd;    // read one stack slot
    logic popWb;    // route the popped byte
    logic popLast;  // final pop: load SP, restore mask
  } seqStrobe_t;

endpackage

// File: rtl/intDispatchCtrl.sv
module intDispatchCtrl
  import intDispatchPkg::*;
#(
  parameter int NUM_SAVED = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic instrBoundary,
  input  logic halted,
  input  logic iretStrobe,
  input  logic pendAny,
  output seqStrobe_t strb,
  output logic [$clog2(NUM_SAVED+2)-1:0] step,
  output logic busy
);
  localparam int SLOTS  = NUM_SAVED + 2;
  localparam int STEP_W = $clog2(SLOTS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SLOTS - 1);

  seqState_t state, stateNext;
  logic [STEP_W-1:0] stepNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    stepNext  = step;
    unique case (state)
      ST_IDLE: begin
        if (instrBoundary && iretStrobe) begin
          strb.latchSp = 1'b1;
          stateNext    = ST_POP_RD;
          stepNext     = '0;
        end else if (instrBoundary && !halted && pendAny) begin
          strb.accept = 1'b1;
          stateNext   = ST_PUSH;
          stepNext    = '0;
        end
      end
      ST_PUSH: begin
        strb.pushEn = 1'b1;
        if (step == LAST) stateNext = ST_VEC_RD;
        else              stepNext  = step + 1'b1;
      end
      ST_VEC_RD: begin
        strb.vecRd = 1'b1;
        stateNext  = ST_VEC_LD;
      end
      ST_VEC_LD: begin
        strb.vecLoad = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_POP_RD: begin
        strb.popRd = 1'b1;
        stateNext  = ST_POP_WB;
      end
      ST_POP_WB: begin
        strb.popWb = 1'b1;
        if (step == LAST) begin
          strb.popLast = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          stepNext  = step + 1'b1;
          stateNext = ST_POP_RD;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
    end
  end

  assign busy = (state != ST_IDLE) | strb.accept | strb.latchSp;

endmodule

// File: rtl/intDispatchDp.sv
module intDispatchDp
  import intDispatchPkg::*;
#(
  parameter int W         = 8,
  parameter int NUM_IRQ   = 8,
  parameter int NUM_SAVED = 7,
  parameter logic [W-1:0] VEC_BASE = 8'hF8
) (
  input  logic clk,
  input  logic rst_n,
  input  seqStrobe_t strb,
  input  logic [$clog2(NUM_SAVED+2)-1:0] step,
  output logic pendAny,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic intStrobe,
  input  logic [$clog2(NUM_IRQ)-1:0] intNum,
  input  logic imWrEn,
  input  logic [NUM_IRQ-1:0] imWrData,
  output logic [NUM_IRQ-1:0] imOut,
  output logic [NUM_IRQ-1:0] isOut,
  output logic memWrEn,
  output logic memRdEn,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWrData,
  input  logic [W-1:0] memRdData,
  input  logic [W-1:0] spIn,
  output logic spLoad,
  output logic [W-1:0] spOut,
  input  logic [W-1:0] pcIn,
  output logic pcLoad,
  output logic [W-1:0] pcOut,
  input  logic [W-1:0] flagsIn,
  output logic flagsLoad,
  output logic [W-1:0] flagsOut,
  output logic [$clog2(NUM_SAVED+1)-1:0] regRdIdx,
  input  logic [W-1:0] regRdData,
  output logic regWrEn,
  output logic [$clog2(NUM_SAVED+1)-1:0] regWrIdx,
  output logic [W-1:0] regWrData
);
  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int REG_W  = $clog2(NUM_SAVED + 1);
  localparam int STEP_W = $clog2(NUM_SAVED + 2);
  localparam logic [STEP_W-1:0] FLAG_STEP = STEP_W'(NUM_SAVED);
  localparam logic [STEP_W-1:0] PC_STEP   = STEP_W'(NUM_SAVED + 1);

  logic [NUM_IRQ-1:0] imReg, isReg, savedIm, pend, clrMask, setMask;
  logic [IDX_W-1:0]   lowIdx, curNum;
  logic [W-1:0]       spWork;

  assign pend    = imReg & isReg;
  assign pendAny = |pend;

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (pend[i]) lowIdx = IDX_W'(i);
  end

  always_comb begin
    clrMask = '0;
    if (strb.accept) clrMask[lowIdx] = 1'b1;
    setMask = irqReq;
    if (intStrobe) setMask[intNum] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imReg   <= '0;
      isReg   <= '0;
      savedIm <= '0;
      curNum  <= '0;
      spWork  <= '0;
    end else begin
      isReg <= (isReg | setMask) & ~clrMask;
      if (strb.accept) begin
        savedIm <= imReg;
        imReg   <= '0;
        curNum  <= lowIdx;
        spWork  <= spIn;
      end else if (strb.popLast) begin
        imReg <= savedIm;
      end else if (imWrEn) begin
        imReg <= imWrData;
      end
      if (strb.latchSp)     spWork <= spIn;
      else if (strb.pushEn) spWork <= spWork - 1'b1;
      else if (strb.popWb)  spWork <= spWork + 1'b1;
    end
  end

  assign imOut = imReg;
  assign isOut = isReg;

  // memory port
  always_comb begin
    memWrEn   = strb.pushEn;
    memRdEn   = strb.vecRd | strb.popRd;
    memAddr   = spWork;
    memWrData = regRdData;
    regRdIdx  = '0;
    if (strb.pushEn) begin
      memAddr  = spWork - 1'b1;
      regRdIdx = REG_W'(step - 2'd2);
      if (step == '0)                memWrData = pcIn;
      else if (step == STEP_W'(1))   memWrData = flagsIn;
    end else if (strb.vecRd) begin
      memAddr = VEC_BASE + W'(curNum);
    end
  end

  // state loads
  always_comb begin
    pcLoad    = 1'b0;
    pcOut     = memRdData;
    flagsLoad = 1'b0;
    flagsOut  = memRdData;
    regWrEn   = 1'b0;
    regWrIdx  = '0;
    regWrData = memRdData;
    spLoad    = strb.vecLoad | strb.popLast;
    spOut     = strb.popLast ? spWork + 1'b1 : spWork;
    if (strb.vecLoad) pcLoad = 1'b1;
    if (strb.popWb) begin
      if (step == PC_STEP)        pcLoad    = 1'b1;
      else if (step == FLAG_STEP) flagsLoad = 1'b1;
      else begin
        regWrEn  = 1'b1;
        regWrIdx = REG_W'(NUM_SAVED - 1) - REG_W'(step);
      end
    end
  end

endmodule

// File: rtl/intDispatch.sv
module intDispatch
  import intDispatchPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irqReq,
  input  logic       intStrobe,
  input  logic [2:0] intNum,
  input  logic       imWrEn,
  input  logic [7:0] imWrData,
  output logic [7:0] imOut,
  output logic [7:0] isOut,
  input  logic       instrBoundary,
  input  logic       halted,
  input  logic       iretStrobe,
  output logic       busy,
  output logic       memWrEn,
  output logic       memRdEn,
  output logic [7:0] memAddr,
  output logic [7:0] memWrData,
  input  logic [7:0] memRdData,
  input  logic [7:0] spIn,
  output logic       spLoad,
  output logic [7:0] spOut,
  input  logic [7:0] pcIn,
  output logic       pcLoad,
  output logic [7:0] pcOut,
  input  logic [7:0] flagsIn,
  output logic       flagsLoad,
  output logic [7:0] flagsOut,
  output logic [2:0] regRdIdx,
  input  logic [7:0] regRdData,
  output logic       regWrEn,
  output logic [2:0] regWrIdx,
  output logic [7:0] regWrData
);
  localparam int NUM_SAVED = 7;
  localparam int STEP_W    = $clog2(NUM_SAVED + 2);

  seqStrobe_t        strb;
  logic [STEP_W-1:0] step;
  logic              pendAny;

  intDispatchCtrl #(.NUM_SAVED(NUM_SAVED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .instrBoundary(instrBoundary), .halted(halted),
    .iretStrobe(iretStrobe), .pendAny(pendAny), .strb(strb), .step(step),
    .busy(busy)
  );

  intDispatchDp #(.W(8), .NUM_IRQ(8), .NUM_SAVED(NUM_SAVED), .VEC_BASE(8'hF8)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .step(step), .pendAny(pendAny),
    .irqReq(irqReq), .intStrobe(intStrobe), .intNum(intNum),
    .imWrEn(imWrEn), .imWrData(imWrData), .imOut(imOut), .isOut(isOut),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData),
    .spIn(spIn), .spLoad(spLoad), .spOut(spOut),
    .pcIn(pcIn), .pcLoad(pcLoad), .pcOut(pcOut),
    .flagsIn(flagsIn), .flagsLoad(flagsLoad), .flagsOut(flagsOut),
    .regRdIdx(regRdIdx), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData)
  );

endmodule

// File: rtl/intDispatchChk.sv
module intDispatchChk (
  input logic       clk,
  input logic       rst_n,
  input logic       halted,
  input logic       busy,
  input logic       memWrEn,
  input logic       memRdEn,
  input logic [7:0] memAddr,
  input logic [7:0] imOut,
  input logic       pcLoad,
  input logic       flagsLoad,
  input logic       regWrEn
);
  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(memWrEn && memRdEn)); // R10

  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pcLoad || flagsLoad || regWrEn) |-> $past(memRdEn)); // R10

  AST_MASK_OFF_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> imOut == 8'h00); // R3

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn && $past(memWrEn)) |-> memAddr == $past(memAddr) - 8'd1); // R4

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> busy); // R9

  AST_HALT_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !busy) |=> !memWrEn); // R8

endmodule

bind intDispatch intDispatchChk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .busy(busy),
  .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr), .imOut(imOut),
  .pcLoad(pcLoad), .flagsLoad(flagsLoad), .regWrEn(regWrEn)
);

// File: tb/sim_intDispatch.sv
module sim_intDispatch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] irqReq = '0;
  logic intStrobe = 1'b0;
  logic [2:0] intNum = '0;
  logic imWrEn = 1'b0;
  logic [7:0] imWrData = '0;
  logic [7:0] imOut, isOut;
  logic instrBoundary = 1'b0, halted = 1'b0, iretStrobe = 1'b0;
  logic busy, memWrEn, memRdEn, spLoad, pcLoad, flagsLoad, regWrEn;
  logic [7:0] memAddr, memWrData, spOut, pcOut, flagsOut, regWrData;
  logic [2:0] regRdIdx, regWrIdx;

  // core model
  logic [7:0] mem [256];
  logic [7:0] regs [8];
  logic [7:0] sp, pc, flags, rdData;
  logic pEn = 1'b0;
  logic [7:0] pSp = '0, pPc = '0, pFlags = '0, pRegBase = '0;

  function automatic logic [7:0] vecVal(input int n);
    return 8'(8'h40 + n * 5);
  endfunction

  always @(posedge clk) begin
    if (pEn) begin
      sp <= pSp; pc <= pPc; flags <= pFlags;
      for (int k = 0; k < 8; k++) regs[k] <= 8'(pRegBase + k);
      for (int k = 0; k < 8; k++) mem[8'hF8 + k] <= vecVal(k);
    end else begin
      if (memWrEn) mem[memAddr] <= memWrData;
      if (spLoad) sp <= spOut;
      if (pcLoad) pc <= pcOut;
      if (flagsLoad) flags <= flagsOut;
      if (regWrEn) regs[regWrIdx] <= regWrData;
    end
    rdData <= mem[memAddr];
  end

  intDispatch u0 (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .intStrobe(intStrobe),
    .intNum(intNum), .imWrEn(imWrEn), .imWrData(imWrData), .imOut(imOut),
    .isOut(isOut), .instrBoundary(instrBoundary), .halted(halted),
    .iretStrobe(iretStrobe), .busy(busy), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(rdData), .spIn(sp), .spLoad(spLoad), .spOut(spOut),
    .pcIn(pc), .pcLoad(pcLoad), .pcOut(pcOut), .flagsIn(flags),
    .flagsLoad(flagsLoad), .flagsOut(flagsOut), .regRdIdx(regRdIdx),
    .regRdData(regs[regRdIdx]), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData)
  );

  int nChecks = 0;
  int nFails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic preset(input logic [7:0] s, input logic [7:0] p,
                        input logic [7:0] f, input logic [7:0] rb);
    pSp = s; pPc = p; pFlags = f; pRegBase = rb; pEn = 1'b1;
    @(negedge clk);
    pEn = 1'b0;
  endtask

  task automatic writeMask(input logic [7:0] m);
    imWrData = m; imWrEn = 1'b1;
    @(negedge clk);
    imWrEn = 1'b0;
  endtask

  // one boundary cycle, then count busy cycles until idle
  task automatic runBoundary(input bit isRet, output int cyc);
    instrBoundary = 1'b1; iretStrobe = isRet;
    cyc = 0;
    #1;
    while (busy && cyc < 100) begin
      cyc++;
      @(posedge clk);
      @(negedge clk);
      instrBoundary = 1'b0; iretStrobe = 1'b0;
      #1;
    end
    if (cyc == 0) begin
      @(negedge clk);
      instrBoundary = 1'b0; iretStrobe = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] expIs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imOut == 8'h00, "R1 reset mask", imOut, 0);
    chk(isOut == 8'h00, "R1 reset status", isOut, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);

    // raise all eight requests with one pulse
    irqReq = 8'hFF;
    @(negedge clk);
    irqReq = 8'h00;
    chk(isOut == 8'hFF, "R7 pulse sets status", isOut, 8'hFF);
    chk(imOut == 8'h00, "R7 mask untouched", imOut, 0);
    writeMask(8'hFF);

    for (int n = 0; n < 8; n++) begin
      logic [7:0] s0, p0, f0, rb;
      s0 = 8'(8'hF4 - n); p0 = 8'(8'h20 + n); f0 = 8'(n + 1); rb = 8'(n * 16 + 1);
      preset(s0, p0, f0, rb);
      expIs = 8'(8'hFF << n);
      runBoundary(1'b0, cyc);
      chk(cyc == 12, "R9 entry busy length", cyc, 12);
      chk(pc == vecVal(n), "R5 handler vector", pc, vecVal(n));
      chk(sp == 8'(s0 - 9), "R4 final sp", sp, 8'(s0 - 9));
      chk(isOut == 8'(expIs & ~(8'h01 << n)), "R2 R3 lowest bit cleared",
          isOut, 8'(expIs & ~(8'h01 << n)));
      chk(imOut == 8'h00, "R3 mask cleared", imOut, 0);
      chk(mem[8'(s0 - 1)] == p0, "R4 pc slot", mem[8'(s0 - 1)], p0);
      chk(mem[8'(s0 - 2)] == f0, "R4 flags slot", mem[8'(s0 - 2)], f0);
      for (int k = 0; k < 7; k++)
        chk(mem[8'(s0 - 3 - k)] == 8'(rb + k), "R4 register slot",
            mem[8'(s0 - 3 - k)], 8'(rb + k));
      // clobber everything, then return
      preset(8'(s0 - 9), 8'hEE, 8'hEE, 8'hA0);
      runBoundary(1'b1, cyc);
      chk(cyc == 19, "R9 return busy length", cyc, 19);
      chk(pc == p0, "R6 pc restored", pc, p0);
      chk(flags == f0, "R6 flags restored", flags, f0);
      chk(sp == s0, "R6 sp restored", sp, s0);
      chk(imOut == 8'hFF, "R6 mask restored", imOut, 8'hFF);
      for (int k = 0; k < 7; k++)
        chk(regs[k] == 8'(rb + k), "R6 register restored", regs[k], 8'(rb + k));
    end
    chk(isOut == 8'h00, "R2 all serviced", isOut, 0);

    // software interrupt, gated by mask then by halt
    intNum = 3'd6; intStrobe = 1'b1;
    @(negedge clk);
    intStrobe = 1'b0;
    chk(isOut == 8'h40, "R7 software sets status", isOut, 8'h40);
    writeMask(8'h00);
    preset(8'hF4, 8'h33, 8'h05, 8'h50);
    runBoundary(1'b0, cyc);
    chk(cyc == 0, "R1 masked no entry", cyc, 0);
    chk(pc == 8'h33 && sp == 8'hF4, "R1 masked state kept", pc, 8'h33);
    writeMask(8'hFF);
    halted = 1'b1;
    runBoundary(1'b0, cyc);
    chk(cyc == 0, "R8 halted no entry", cyc, 0);
    chk(isOut == 8'h40, "R8 status kept", isOut, 8'h40);
    chk(pc == 8'h33, "R8 pc kept", pc, 8'h33);
    halted = 1'b0;
    runBoundary(1'b0, cyc);
    chk(cyc == 12, "R7 software entry", cyc, 12);
    chk(pc == vecVal(6), "R5 software vector", pc, vecVal(6));
    chk(isOut == 8'h00, "R3 software bit cleared", isOut, 0);
    runBoundary(1'b1, cyc);
    chk(pc == 8'h33 && imOut == 8'hFF, "R6 software return", pc, 8'h33);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule